// File: doc/BRIEF.md
# Fast-Lock Timeout Sequencer

This block sequences the fast-lock phase of a frequency-synthesizer loop. Software loads three 9-bit timeout values through a 24-bit register write port. One value times the loop-filter switch pair, one times a third switch, and one times the charge-pump current boost. All three counters advance on a tick that fires once every four reference cycles.

A write to the frequency register starts all three counters. It arrives either on a dedicated pulse input or as a register write with control code 000. From that edge both switch outputs are driven high and the current multiplier is set to 64x. Each switch output drops when its own counter runs out. When the current counter runs out, the multiplier walks down by halving, one step per tick, until it reaches 1x. It then rests there until the next start.

Top module: `fastlock_seq`

## Requirements
- R1: After reset both switch outputs are low, `cp_mult` is 7'b0000001 (1x), and all three programmed timeout values are zero.
- R2: A cycle with `wr_en` high and `wr_word[2:0]` equal to 3'b100 stores `wr_word[13:5]` as a timeout value. The target is chosen by `wr_word[4:3]`: 2'b00 the switch-pair timeout, 2'b01 the third-switch timeout, 2'b10 the current timeout.
- R3: A timeout write with `wr_word[4:3]` equal to 2'b11 changes nothing. A write whose `wr_word[2:0]` is neither 3'b100 nor 3'b000 changes nothing. `wr_word[23:14]` is ignored.
- R4: A start is `freq_wr` high in a cycle, or `wr_en` high with `wr_word[2:0]` equal to 3'b000. At the edge that samples it, `sw12_on` and `sw3_on` go high and `cp_mult` becomes 7'b1000000 (64x).
- R5: `sw12_on` stays high for exactly 4·max(N,1) clock cycles after the start edge, where N is the programmed switch-pair value. It then stays low until the next start.
- R6: `sw3_on` behaves as in R5, using the third-switch value.
- R7: With current value N, `cp_mult` holds 64x for 4·max(N,1) cycles after the start edge. It then halves, and halves again every 4 cycles, through 32, 16, 8, 4, 2 to 1. It holds 1x until the next start.
- R8: A start during a count or a ramp aborts it at once and reloads all counters from the programmed values. A start wins over an expiry that falls on the same edge.
- R9: A timeout write made while the counters run does not change the running count. The new value takes effect at the next start.
- R10: `cp_mult` always has exactly one bit set. It never moves except by halving or by a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 24 | Write word; bits 2:0 select the register |
| freq_wr | input | 1 | Frequency-register write pulse (start) |
| sw12_on | output | 1 | Loop-filter switch-pair enable |
| sw3_on | output | 1 | Third-switch enable |
| cp_mult | output | 7 | One-hot charge-pump current multiplier, bit k means 2^k |

## Verification
A start and a counter expiry can land on the same edge. The bench stops watching a run one cycle before a known expiry edge and raises `freq_wr` so that the start is sampled on that edge. It then expects the switches still high and the multiplier at 64x rather than the expiry step. A start falling on a ramp step is provoked and judged in the same way, as is a timeout write issued mid-run, which must leave the running count untouched.

// File: rtl/fl_pkg.sv
package fl_pkg;
   typedef enum logic [1:0] {
      TSEL_SW12 = 2'b00,
      TSEL_SW3  = 2'b01,
      TSEL_CP   = 2'b10,
      TSEL_NONE = 2'b11
   } tsel_e;

   localparam logic [2:0] CTRL_FREQ = 3'b000;
   localparam logic [2:0] CTRL_TMO  = 3'b100;
   localparam int         NUM_TMO   = 3;
endpackage

// File: rtl/fl_cfg_regs.sv
module fl_cfg_regs #(
   parameter int CNT_W = 9,
   parameter int NUM   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hit,
   input  logic [1:0]                sel,
   input  logic [CNT_W-1:0]          val,
   output logic [NUM-1:0][CNT_W-1:0] prog
);
   for (genvar gi = 0; gi < NUM; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prog[gi] <= '0;
         end else if (hit && (sel == 2'(gi))) begin
            prog[gi] <= val;
         end
      end
   end
endmodule

// File: rtl/fl_prescaler.sv
module fl_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

   logic [DIV_W-1:0] phase_q;

   assign tick = (phase_q == LAST);

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= '0;
         else if (restart) phase_q <= '0;
         else              phase_q <= phase_q + 1'b1;
      end
   end else begin : g_any
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= '0;
         else if (restart) phase_q <= '0;
         else if (tick)    phase_q <= '0;
         else              phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/fl_timeout.sv
module fl_timeout #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] load,
   output logic             active,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last   = (cnt_q <= ONE);
   assign expire = tick && active && last && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt_q  <= load;
         active <= 1'b1;
      end else if (tick && active) begin
         if (last) active <= 1'b0;
         else      cnt_q  <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/fl_ramp.sv
module fl_ramp #(
   parameter int STEPS = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           tick,
   input  logic           expire,
   output logic [STEPS:0] mult
);
   localparam logic [STEPS:0] MULT_TOP = {1'b1, {STEPS{1'b0}}};
   localparam logic [STEPS:0] MULT_BOT = {{STEPS{1'b0}}, 1'b1};

   logic ramp_q;
   logic step;

   assign step = (expire || (ramp_q && tick)) && !mult[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult   <= MULT_BOT;
         ramp_q <= 1'b0;
      end else if (start) begin
         mult   <= MULT_TOP;
         ramp_q <= 1'b0;
      end else begin
         if (expire) ramp_q <= 1'b1;
         if (step)   mult   <= mult >> 1;
      end
   end
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq #(
   parameter int WORD_W     = 24,
   parameter int CNT_W      = 9,
   parameter int DIV        = 4,
   parameter int RAMP_STEPS = 6,
   parameter int SEL_LSB    = 3,
   parameter int VAL_LSB    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [WORD_W-1:0]     wr_word,
   input  logic                  freq_wr,
   output logic                  sw12_on,
   output logic                  sw3_on,
   output logic [RAMP_STEPS:0]   cp_mult
);
   import fl_pkg::*;

   localparam int MULT_W = RAMP_STEPS + 1;

   if (DIV < 2) begin : g_bad_div
      $error("fastlock_seq: DIV must be at least 2");
   end
   if (VAL_LSB + CNT_W > WORD_W) begin : g_bad_val
      $error("fastlock_seq: timeout field exceeds word");
   end
   if (SEL_LSB + 2 > VAL_LSB || SEL_LSB < 3) begin : g_bad_sel
      $error("fastlock_seq: select field overlaps");
   end

   logic [2:0]                     ctrl;
   logic                           start;
   logic                           tmo_hit;
   logic                           tick;
   logic [NUM_TMO-1:0][CNT_W-1:0]  prog;
   logic [NUM_TMO-1:0]             active;
   logic [NUM_TMO-1:0]             expire;

   assign ctrl    = wr_word[2:0];
   assign start   = freq_wr || (wr_en && (ctrl == CTRL_FREQ));
   assign tmo_hit = wr_en && (ctrl == CTRL_TMO);

   fl_cfg_regs #(.CNT_W(CNT_W), .NUM(NUM_TMO)) i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (tmo_hit),
      .sel   (wr_word[SEL_LSB +: 2]),
      .val   (wr_word[VAL_LSB +: CNT_W]),
      .prog  (prog)
   );

   fl_prescaler #(.DIV(DIV)) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .tick    (tick)
   );

   for (genvar gi = 0; gi < NUM_TMO; gi++) begin : g_tmo
      fl_timeout #(.CNT_W(CNT_W)) i_tmo (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (start),
         .tick   (tick),
         .load   (prog[gi]),
         .active (active[gi]),
         .expire (expire[gi])
      );
   end

   fl_ramp #(.STEPS(RAMP_STEPS)) i_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tick   (tick),
      .expire (expire[int'(TSEL_CP)]),
      .mult   (cp_mult)
   );

   assign sw12_on = active[int'(TSEL_SW12)];
   assign sw3_on  = active[int'(TSEL_SW3)];
endmodule

// File: rtl/fl_seq_chk.sv
module fl_seq_chk #(
   parameter int WORD_W = 24,
   parameter int MULT_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_word,
   input logic              freq_wr,
   input logic              sw12_on,
   input logic              sw3_on,
   input logic [MULT_W-1:0] cp_mult
);
   localparam logic [MULT_W-1:0] TOP = {1'b1, {(MULT_W-1){1'b0}}};

   logic st;
   assign st = freq_wr || (wr_en && (wr_word[2:0] == 3'b000));

   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      st |=> (sw12_on && sw3_on && cp_mult == TOP)); // R4

   AST_MULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cp_mult) == 1); // R10

   AST_MULT_ONLY_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      !st |=> (cp_mult == $past(cp_mult) || cp_mult == ($past(cp_mult) >> 1))); // R7

   AST_SW12_NO_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      !st |=> !$rose(sw12_on)); // R5

   AST_SW3_NO_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      !st |=> !$rose(sw3_on)); // R6
endmodule

bind fastlock_seq fl_seq_chk #(.WORD_W(WORD_W), .MULT_W(MULT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_word (wr_word),
   .freq_wr (freq_wr),
   .sw12_on (sw12_on),
   .sw3_on  (sw3_on),
   .cp_mult (cp_mult)
);

// File: tb/test_fastlock_seq.sv
module test_fastlock_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        freq_wr = 1'b0;
   logic [23:0] wr_word = '0;
   logic        sw12_on;
   logic        sw3_on;
   logic [6:0]  cp_mult;

   always #4 clk = ~clk;

   fastlock_seq i_fastlock_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .freq_wr(freq_wr), .sw12_on(sw12_on), .sw3_on(sw3_on), .cp_mult(cp_mult)
   );

   int checks = 0;
   int fails  = 0;
   int p12 = 0, p3 = 0, pcp = 0;
   int k12 = 1, k3 = 1, kcp = 1;

   function automatic int kof(int n);
      return (n == 0) ? 1 : n;
   endfunction

   function automatic logic [6:0] exp_mult(int t, int k);
      int s;
      if (t < 4 * k) return 7'h40;
      s = (t - 4 * k) / 4 + 1;
      if (s > 6) s = 6;
      return 7'h40 >> s;
   endfunction

   task automatic chk(string tag, bit ok, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_at(string ctx, int t);
      chk({ctx, "/R5 sw12"}, sw12_on == (t < 4 * k12), sw12_on, t < 4 * k12);
      chk({ctx, "/R6 sw3"}, sw3_on == (t < 4 * k3), sw3_on, t < 4 * k3);
      chk({ctx, "/R7 mult"}, cp_mult == exp_mult(t, kcp), cp_mult, exp_mult(t, kcp));
      chk({ctx, "/R10 onehot"}, $countones(cp_mult) == 1, cp_mult, 1);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic prog(int sel, int val, logic [2:0] ctrl = 3'b100);
      wr_word = {10'h001, 9'(val), 2'(sel), ctrl};
      wr_en   = 1'b1;
      step();
      wr_en   = 1'b0;
      if (ctrl == 3'b100) begin
         if (sel == 0) p12 = val;
         if (sel == 1) p3  = val;
         if (sel == 2) pcp = val;
      end
   endtask

   task automatic start(string ctx, bit via_word);
      if (via_word) begin
         wr_word = {10'h3ff, 9'h1ff, 2'b10, 3'b000};
         wr_en   = 1'b1;
      end else begin
         freq_wr = 1'b1;
      end
      step();
      wr_en = 1'b0;
      freq_wr = 1'b0;
      k12 = kof(p12); k3 = kof(p3); kcp = kof(pcp);
      chk({ctx, "/R4 arm"}, sw12_on && sw3_on && cp_mult == 7'h40,
          {sw12_on, sw3_on, cp_mult}, {2'b11, 7'h40});
   endtask

   task automatic run(string ctx, int t0, int t1);
      for (int t = t0 + 1; t <= t1; t++) begin
         step();
         check_at(ctx, t);
      end
   endtask

   function automatic int full_len();
      int m;
      m = 4 * (kcp + 6);
      if (4 * k12 > m) m = 4 * k12;
      if (4 * k3 > m) m = 4 * k3;
      return m + 3;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog all-R actual=190000 cycles expected=fewer");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 sw12", sw12_on == 1'b0, sw12_on, 0);
      chk("R1 sw3", sw3_on == 1'b0, sw3_on, 0);
      chk("R1 mult", cp_mult == 7'h01, cp_mult, 1);
      // R1: programmed values are zero -> all expire on the first tick
      start("R1", 1'b0);
      run("R1", 0, full_len());

      // R2: distinct values per select code, current expires first
      prog(0, 9); prog(1, 5); prog(2, 2);
      start("R2", 1'b0);
      run("R2", 0, full_len());

      // R3: ignored writes
      prog(3, 300);
      prog(0, 77, 3'b010);
      prog(1, 88, 3'b111);
      prog(2, 99, 3'b101);
      chk("R3 idle sw", !sw12_on && !sw3_on, {sw12_on, sw3_on}, 0);
      chk("R3 idle mult", cp_mult == 7'h01, cp_mult, 1);
      start("R3", 1'b0);
      run("R3", 0, full_len());

      // R4: start through a control-000 register write
      start("R4", 1'b1);
      run("R4", 0, full_len());

      // R8: abort mid-count
      start("R8", 1'b0);
      run("R8", 0, 13);
      start("R8", 1'b0);
      run("R8", 0, full_len());

      // R8: start on the exact expiry edge of all three counters
      prog(0, 3); prog(1, 3); prog(2, 3);
      start("R8", 1'b0);
      run("R8", 0, 11);
      start("R8", 1'b0);
      run("R8", 0, 14);
      // R8: start on a ramp step edge
      start("R8", 1'b0);
      run("R8", 0, 4 * 3 + 4 * 2 - 1);
      start("R8", 1'b0);
      run("R8", 0, full_len());

      // R9: mid-run programming leaves the running count
      prog(0, 6); prog(1, 4); prog(2, 3);
      start("R9", 1'b0);
      run("R9", 0, 5);
      prog(2, 12);
      check_at("R9", 6);
      prog(0, 2);
      check_at("R9", 7);
      run("R9", 7, full_len());
      start("R9", 1'b0);
      run("R9", 0, full_len());

      // R5 R6 R7: top of range
      prog(0, 511); prog(1, 510); prog(2, 504);
      start("R5", 1'b0);
      run("R5", 0, full_len());

      // random mix
      for (int it = 0; it < 40; it++) begin
         for (int w = 0; w < 4; w++) begin
            int sel, val, c;
            sel = $urandom_range(3, 0);
            val = ($urandom_range(9, 0) == 0) ? $urandom_range(511, 0) : $urandom_range(40, 0);
            c = $urandom_range(5, 0);
            if (c == 0) prog(sel, val, 3'b011);
            else        prog(sel, val);
         end
         start("R8", $urandom_range(1, 0) == 1);
         if ($urandom_range(3, 0) == 0) begin
            int cut;
            cut = $urandom_range(full_len(), 1);
            run("R8", 0, cut);
            start("R8", 1'b0);
         end
         run("R9", 0, full_len());
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule